// File: doc/BRIEF.md
# Bitwise Quaternary Gate

This block applies one two-input Boolean function, bit by bit, to two one-hot coded operands. Each operand is one digit sent on four wires. A digit holds two binary bits. The function is applied to bit 0 of both operands and, separately, to bit 1 of both operands. The result is sent back as a one-hot digit. The function (AND, OR or XOR) is fixed when the block is elaborated. The logic is a table indexed by the pair of operand values. The block never turns the operands into binary words and then works on them.

The block follows a return-to-zero handshake. An all-zero word (the spacer) separates consecutive data words. The output register acts like a completion element. It takes a data value only when both operands carry data. It goes back to the spacer only when both operands are spacers. At any other time it holds its value. A word with more than one wire high on either operand is illegal. Such a word sets an error flag and leaves the result unchanged.

Top module: `qgate_bitwise`

## Requirements
- R1: While reset is asserted, and right after it, `q_o` is the spacer (all zero) and `err_o` is 0.
- R2: A digit value v (bit 0 is its LSB) is coded by driving wire v alone high: 0→0001, 1→0010, 2→0100, 3→1000. All-zero is the spacer. `q_o` always has at most one wire high.
- R3: With the AND function, the result digit has bit0 = a.bit0 & b.bit0 and bit1 = a.bit1 & b.bit1.
- R4: With the OR function, each result bit is the OR of the matching operand bits.
- R5: With the XOR function, each result bit is the XOR of the matching operand bits.
- R6: If `q_o` is the spacer and both operands carry legal data at a rising clock edge, `q_o` shows the coded result after that edge.
- R7: If `q_o` is the spacer and only one operand carries data, `q_o` stays the spacer.
- R8: If `q_o` holds data, it returns to the spacer only at an edge where both operands are spacers. If only one operand is a spacer, `q_o` keeps its data.
- R9: If `q_o` holds data and the operands change to other data without first passing through the spacer, `q_o` keeps its old value.
- R10: If either operand has two or more wires high at an edge, `err_o` is 1 after that edge and `q_o` keeps its value. `err_o` goes back to 0 after the next edge at which both operands are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_i | input | 4 | Operand A, one-hot digit or spacer |
| b_i | input | 4 | Operand B, one-hot digit or spacer |
| q_o | output | 4 | Result digit, one-hot or spacer |
| err_o | output | 1 | Illegal operand code seen at the last edge |

## Verification
All 16 operand pairs are applied to an AND, an OR and an XOR instance at the same time, with a spacer after each pair. Each pair is compared against a binary model of the two bit operations, so that a swapped bit, a swapped lane or a wrong function shows up. Short sequences then check the completion behaviour:
- one operand arriving before the other;
- one operand withdrawing before the other;
- data changing to new data with no spacer between;
- illegal words arriving both from the spacer state and from the data state.

These sequences separate correct hold behaviour from an output that simply follows its inputs.

// File: rtl/qgate_pkg.sv
package qgate_pkg;

   typedef enum logic [1:0] {
      QFN_AND = 2'd0,
      QFN_OR  = 2'd1,
      QFN_XOR = 2'd2
   } qfn_e;

   // bitwise function on two digit values
   function automatic int bit_op(qfn_e f, int x, int y);
      case (f)
         QFN_AND: return x & y;
         QFN_OR:  return x | y;
         QFN_XOR: return x ^ y;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/qgate_dec.sv
module qgate_dec #(
   parameter int DIG_BITS = 2,
   localparam int WIRES = 1 << DIG_BITS
) (
   input  logic [WIRES-1:0]    code_i,
   output logic [DIG_BITS-1:0] val_o,
   output logic                data_o,
   output logic                spacer_o,
   output logic                bad_o
);

   always_comb begin
      val_o = '0;
      for (int i = 0; i < WIRES; i++) begin
         if (code_i[i]) val_o = DIG_BITS'(i);
      end
   end

   assign spacer_o = (code_i == '0);
   assign data_o   = $onehot(code_i);
   assign bad_o    = !spacer_o && !data_o;

endmodule

// File: rtl/qgate_map.sv
module qgate_map #(
   parameter int               DIG_BITS = 2,
   parameter qgate_pkg::qfn_e  GATE_FN  = qgate_pkg::QFN_AND,
   localparam int WIRES = 1 << DIG_BITS,
   localparam int TBL   = WIRES * WIRES
) (
   input  logic [DIG_BITS-1:0] a_val_i,
   input  logic [DIG_BITS-1:0] b_val_i,
   output logic [WIRES-1:0]    code_o
);

   logic [WIRES-1:0] tbl [TBL];

   // one table entry per operand pair, built at elaboration
   for (genvar k = 0; k < TBL; k++) begin : g_ent
      localparam int AV = k / WIRES;
      localparam int BV = k % WIRES;
      assign tbl[k] = WIRES'(1) << qgate_pkg::bit_op(GATE_FN, AV, BV);
   end

   assign code_o = tbl[{a_val_i, b_val_i}];

endmodule

// File: rtl/qgate_bitwise.sv
module qgate_bitwise #(
   parameter int               DIG_BITS = 2,
   parameter qgate_pkg::qfn_e  GATE_FN  = qgate_pkg::QFN_AND,
   localparam int WIRES = 1 << DIG_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIRES-1:0] a_i,
   input  logic [WIRES-1:0] b_i,
   output logic [WIRES-1:0] q_o,
   output logic             err_o
);

   if (DIG_BITS < 1 || DIG_BITS > 3) begin : g_bad_width
      $error("qgate_bitwise: DIG_BITS must be 1..3");
   end
   if (GATE_FN != qgate_pkg::QFN_AND && GATE_FN != qgate_pkg::QFN_OR &&
       GATE_FN != qgate_pkg::QFN_XOR) begin : g_bad_fn
      $error("qgate_bitwise: unsupported GATE_FN");
   end

   logic [DIG_BITS-1:0] a_val, b_val;
   logic                a_dat, b_dat, a_sp, b_sp, a_bad, b_bad;
   logic [WIRES-1:0]    res_code;
   logic [WIRES-1:0]    q_r;
   logic                err_r;

   qgate_dec #(.DIG_BITS(DIG_BITS)) u_dec_a (
      .code_i(a_i), .val_o(a_val), .data_o(a_dat), .spacer_o(a_sp), .bad_o(a_bad));

   qgate_dec #(.DIG_BITS(DIG_BITS)) u_dec_b (
      .code_i(b_i), .val_o(b_val), .data_o(b_dat), .spacer_o(b_sp), .bad_o(b_bad));

   qgate_map #(.DIG_BITS(DIG_BITS), .GATE_FN(GATE_FN)) u_map (
      .a_val_i(a_val), .b_val_i(b_val), .code_o(res_code));

   // completion register: set on full data, clear on full spacer, else hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r   <= '0;
         err_r <= 1'b0;
      end else if (a_bad || b_bad) begin
         err_r <= 1'b1;
      end else begin
         err_r <= 1'b0;
         if (q_r == '0 && a_dat && b_dat) q_r <= res_code;
         else if (a_sp && b_sp)           q_r <= '0;
      end
   end

   assign q_o   = q_r;
   assign err_o = err_r;

   p_onehot_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_o));

   p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o == '0 && a_dat && b_dat) |=> (q_o != '0));

   p_partial_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o == '0 && !(a_dat && b_dat)) |=> (q_o == '0));

   p_rtz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o != '0 && !(a_sp && b_sp)) |=> $stable(q_o));

   p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_bad || b_bad) |=> (err_o && $stable(q_o)));

endmodule

// File: tb/sim_qgate_bitwise.sv
module sim_qgate_bitwise;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a = '0, b = '0;
   logic [3:0] q_and, q_or, q_xor;
   logic       e_and, e_or, e_xor;
   int         total = 0, bad = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;

   qgate_bitwise #(.GATE_FN(qgate_pkg::QFN_AND)) u0 (
      .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .q_o(q_and), .err_o(e_and));
   qgate_bitwise #(.GATE_FN(qgate_pkg::QFN_OR)) u1 (
      .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .q_o(q_or), .err_o(e_or));
   qgate_bitwise #(.GATE_FN(qgate_pkg::QFN_XOR)) u2 (
      .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .q_o(q_xor), .err_o(e_xor));

   function automatic logic [3:0] enc(int v);
      return 4'b0001 << v;
   endfunction

   task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   // drive at negedge, sample at the following negedge (one posedge between)
   task automatic step(logic [3:0] na, logic [3:0] nb);
      @(negedge clk);
      a = na;
      b = nb;
      @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 q during reset", q_and, 4'b0000);
      chk("R1 err during reset", {3'b000, e_and}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 q after reset", q_xor, 4'b0000);
   endtask

   task automatic t_truth;
      for (int x = 0; x < 4; x++) begin
         for (int y = 0; y < 4; y++) begin
            step(enc(x), enc(y));
            chk("R3 AND / R6", q_and, enc(x & y));
            chk("R4 OR", q_or, enc(x | y));
            chk("R5 XOR", q_xor, enc(x ^ y));
            step(4'b0000, 4'b0000);
            chk("R8 spacer after vector (R2)", q_and | q_or | q_xor, 4'b0000);
         end
      end
   endtask

   task automatic t_partial;
      step(enc(1), 4'b0000);
      chk("R7 only A data", q_or, 4'b0000);
      step(4'b0000, enc(2));
      chk("R7 only B data", q_or, 4'b0000);
      step(enc(1), enc(2));
      chk("R6 both data", q_or, enc(3));
      step(4'b0000, enc(2));
      chk("R8 A spacer only", q_or, enc(3));
      step(enc(1), 4'b0000);
      chk("R8 B spacer only", q_or, enc(3));
      step(4'b0000, 4'b0000);
      chk("R8 both spacer", q_or, 4'b0000);
   endtask

   task automatic t_nospacer;
      step(enc(3), enc(3));
      chk("R9 first data", q_and, enc(3));
      step(enc(0), enc(1));
      chk("R9 new data no spacer AND", q_and, enc(3));
      chk("R9 new data no spacer XOR", q_xor, enc(0));
      step(4'b0000, 4'b0000);
      chk("R9 released", q_and, 4'b0000);
   endtask

   task automatic t_illegal;
      step(enc(1), enc(1));
      chk("R10 setup", q_and, enc(1));
      step(4'b0011, enc(1));
      chk("R10 err from data", {3'b000, e_and}, 4'b0001);
      chk("R10 q held in data", q_and, enc(1));
      step(4'b0000, 4'b0000);
      chk("R10 err cleared", {3'b000, e_and}, 4'b0000);
      chk("R10 spacer after", q_and, 4'b0000);
      step(4'b1111, 4'b0101);
      chk("R10 err from spacer", {3'b000, e_or}, 4'b0001);
      chk("R10 q held spacer", q_or, 4'b0000);
      step(4'b0000, 4'b0000);
      chk("R10 err cleared again", {3'b000, e_or}, 4'b0000);
   endtask

   initial begin
      t_reset();
      t_truth();
      t_partial();
      t_nospacer();
      t_illegal();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule